// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block keeps a handful of recent virtual-page-to-physical-frame translations and answers lookups in the same cycle. Every stored translation carries an address-space identifier. A lookup therefore hits only when both the virtual page number and the identifier of the running process agree. Processes can share the cache without seeing each other's mappings.

On a hit, the frame number is taken from the matching slot and the page offset passes through untouched to form the physical address. On a miss, the block raises a miss flag so that an external table walker fetches the translation from memory. The walker then writes the translation back through the refill port.

Entries can be dropped all at once, for example on a global mapping change. They can also be dropped selectively for one identifier when that process's mappings are retired. Refills go to a free slot first, and only a full cache evicts a slot, in rotating order.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid, so every lookup misses.
- R2: A lookup hits only when some valid slot holds both the requested page number and the requested identifier. On a hit, `lk_paddr` equals the slot's frame number followed by the unchanged low OFF_W bits of `lk_vaddr`, in the same cycle as the request.
- R3: With `lk_valid` high and no matching slot, `lk_miss` is high and `lk_hit` is low. With `lk_valid` low, both flags are low.
- R4: A refill accepted on one clock edge is visible to lookups in the cycle that follows.
- R5: A refill with no existing match goes into the lowest-numbered invalid slot when one exists, and it disturbs no valid slot.
- R6: When all slots are valid, a refill with no existing match evicts the slot under a rotating pointer. The pointer starts at slot 0 after reset and advances by one only on such an eviction.
- R7: A refill whose page number and identifier already sit in a valid slot rewrites that slot's frame number in place. It evicts nothing and leaves the rotating pointer where it was.
- R8: Asserting `inv_all` clears every slot on that edge and drops any refill presented in the same cycle.
- R9: A flush by identifier clears, on one edge, exactly the slots that carry that identifier. A refill in the same cycle still lands and stays valid.
- R10: No lookup ever finds more than one matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page number above, offset below |
| lk_asid | input | ASID_W | Identifier of the running process |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, table walk needed |
| lk_paddr | output | PFN_W+OFF_W | Physical address on a hit, frame field zero otherwise |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_asid | input | ASID_W | Refill identifier |
| inv_all | input | 1 | Clear every slot |
| inv_asid_en | input | 1 | Clear slots carrying `inv_asid` |
| inv_asid | input | ASID_W | Identifier to clear |

## Verification
The hardest state to reach from the ports is the choice of victim. The rotating pointer and the free-slot search are both hidden, and they show only through which earlier translation stops hitting. The stimulus fills every slot in a known order and then forces further refills. In between, it carves holes at chosen slots with a flush by identifier. Lookups of every previously written page then reveal which slot was reused. An in-place update inserted before the first eviction shows that it neither evicts a slot nor moves the pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // how a refill selects its slot
  typedef enum logic [1:0] {
    FK_UPDATE = 2'd0,  // same page and identifier already stored
    FK_FREE   = 2'd1,  // an invalid slot is available
    FK_EVICT  = 2'd2   // all slots valid, rotating victim
  } fill_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hits
);
  // one comparator pair per slot, all in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (vpn[g] == key_vpn) && (asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     upd_hits,
  input  logic             fill_go,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx, upd_idx;
  logic             free_any;
  fill_kind_e       kind;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    upd_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (upd_hits[i]) upd_idx = IDX_W'(i);
    end
    if (|upd_hits)     kind = FK_UPDATE;
    else if (free_any) kind = FK_FREE;
    else               kind = FK_EVICT;
    case (kind)
      FK_UPDATE: slot = upd_idx;
      FK_FREE:   slot = free_idx;
      default:   slot = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (fill_go && kind == FK_EVICT) begin
      ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic                     clr_all,
  input  logic                     clr_asid_en,
  input  logic [ASID_W-1:0]        clr_asid,
  output logic [N-1:0]             valid,
  output logic [N-1:0][VPN_W-1:0]  vpn,
  output logic [N-1:0][PFN_W-1:0]  pfn,
  output logic [N-1:0][ASID_W-1:0] asid
);
  // valid bits carry reset; payload needs none
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      valid <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (clr_asid_en && asid[i] == clr_asid) valid[i] <= 1'b0;
      end
      if (wr_en) valid[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) begin
      vpn[wr_idx]  <= wr_vpn;
      pfn[wr_idx]  <= wr_pfn;
      asid[wr_idx] <= wr_asid;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VPN_W+OFF_W-1:0]  lk_vaddr,
  input  logic [ASID_W-1:0]       lk_asid,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic [PFN_W+OFF_W-1:0]  lk_paddr,
  input  logic                    fill_en,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic                    inv_all,
  input  logic                    inv_asid_en,
  input  logic [ASID_W-1:0]       inv_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             s_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]  s_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0]  s_pfn;
  logic [ENTRIES-1:0][ASID_W-1:0] s_asid;
  logic [ENTRIES-1:0]             lk_hits, upd_hits;
  logic [IDX_W-1:0]               fill_slot;
  logic [PFN_W-1:0]               pfn_sel;
  logic                           fill_go;

  assign fill_go = fill_en && !inv_all;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(s_valid), .vpn(s_vpn), .asid(s_asid),
    .key_vpn(lk_vaddr[VPN_W+OFF_W-1:OFF_W]), .key_asid(lk_asid),
    .hits(lk_hits)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .valid(s_valid), .vpn(s_vpn), .asid(s_asid),
    .key_vpn(fill_vpn), .key_asid(fill_asid),
    .hits(upd_hits)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .valid(s_valid), .upd_hits(upd_hits),
    .fill_go(fill_go), .slot(fill_slot)
  );

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(fill_go), .wr_idx(fill_slot),
    .wr_vpn(fill_vpn), .wr_pfn(fill_pfn), .wr_asid(fill_asid),
    .clr_all(inv_all), .clr_asid_en(inv_asid_en), .clr_asid(inv_asid),
    .valid(s_valid), .vpn(s_vpn), .pfn(s_pfn), .asid(s_asid)
  );

  // AND-OR frame select, relies on at most one hit
  always_comb begin
    pfn_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      pfn_sel |= s_pfn[i] & {PFN_W{lk_hits[i]}};
    end
  end

  assign lk_hit   = lk_valid && (|lk_hits);
  assign lk_miss  = lk_valid && !(|lk_hits);
  assign lk_paddr = {lk_hit ? pfn_sel : {PFN_W{1'b0}}, lk_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic [ASID_W-1:0]      lk_asid,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_en,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [PFN_W-1:0]       fill_pfn,
  input logic [ASID_W-1:0]      fill_asid,
  input logic                   inv_all,
  input logic                   inv_asid_en,
  input logic [ASID_W-1:0]      inv_asid,
  input logic [ENTRIES-1:0]     lk_hits
);
  p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hits));

  p_flags_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid ? (lk_hit != lk_miss) : (!lk_hit && !lk_miss));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_all)) |-> !lk_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$past(rst) && $past(fill_en && !inv_all)
     && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn) && lk_asid == $past(fill_asid))
    |-> (lk_hit && lk_paddr[PFN_W+OFF_W-1:OFF_W] == $past(fill_pfn)));

  p_clear_asid_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_asid_en && !fill_en) && lk_asid == $past(inv_asid)) |-> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ASID_W(ASID_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
  .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid), .lk_hits(lk_hits)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic        fill_en;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0]  fill_asid;
  logic        inv_all, inv_asid_en;
  logic [7:0]  inv_asid;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; lk_asid = '0;
    fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_asid = '0;
    inv_all = 1'b0; inv_asid_en = 1'b0; inv_asid = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drive a lookup mid-cycle, compare before the next edge
  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [11:0] o,
                      input bit eh, input logic [19:0] ep, input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {v, o}; lk_asid = a;
    #1;
    checks++;
    if (lk_hit !== eh || lk_miss !== !eh || (eh && lk_paddr !== {ep, o})) begin
      bad++;
      $display("FAIL %s vpn=%h asid=%h: hit=%b miss=%b paddr=%h, expected hit=%b paddr=%h",
               rq, v, a, lk_hit, lk_miss, lk_paddr, eh, {ep, o});
    end
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_pfn = p; fill_asid = a;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    look(20'h00000, 8'h00, 12'h000, 1'b0, '0, "R1");
    look(20'h12345, 8'h03, 12'h010, 1'b0, '0, "R1");
  endtask

  task automatic t_basic();
    do_reset();
    fill(20'h12345, 20'hABCDE, 8'h03);
    look(20'h12345, 8'h03, 12'hFFF, 1'b1, 20'hABCDE, "R4");
    look(20'h12345, 8'h03, 12'h000, 1'b1, 20'hABCDE, "R2");
    look(20'h12345, 8'h04, 12'h123, 1'b0, '0, "R2");
    look(20'h12346, 8'h03, 12'h123, 1'b0, '0, "R3");
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = {20'h12345, 12'h0}; lk_asid = 8'h03;
    #1; checks++;
    if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
      bad++;
      $display("FAIL R3 idle: hit=%b miss=%b, expected 0 0", lk_hit, lk_miss);
    end
  endtask

  // rotating eviction plus in-place update
  task automatic t_rotate();
    do_reset();
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 8'h01);
    for (int i = 0; i < 8; i++)
      look(20'h00100 + 20'(i), 8'h01, 12'h004, 1'b1, 20'h00200 + 20'(i), "R5");
    fill(20'h00103, 20'h00333, 8'h01);
    look(20'h00103, 8'h01, 12'h008, 1'b1, 20'h00333, "R7 R10");
    fill(20'h00108, 20'h00208, 8'h01);
    look(20'h00100, 8'h01, 12'h000, 1'b0, '0, "R6 slot0 evicted");
    look(20'h00101, 8'h01, 12'h000, 1'b1, 20'h00201, "R6");
    look(20'h00103, 8'h01, 12'h000, 1'b1, 20'h00333, "R7 no eviction");
    look(20'h00108, 8'h01, 12'h000, 1'b1, 20'h00208, "R6");
    fill(20'h00109, 20'h00209, 8'h01);
    look(20'h00101, 8'h01, 12'h000, 1'b0, '0, "R6 slot1 evicted");
    look(20'h00102, 8'h01, 12'h000, 1'b1, 20'h00202, "R6");
    look(20'h00108, 8'h01, 12'h000, 1'b1, 20'h00208, "R6");
  endtask

  // holes from a per-identifier flush are reused before evicting
  task automatic t_holes();
    do_reset();
    for (int i = 0; i < 8; i++)
      fill(20'h00300 + 20'(i), 20'h00600 + 20'(i), (i % 2 == 1) ? 8'h02 : 8'h01);
    @(negedge clk);
    inv_asid_en = 1'b1; inv_asid = 8'h02;
    @(posedge clk); #1;
    inv_asid_en = 1'b0;
    for (int i = 0; i < 8; i++)
      look(20'h00300 + 20'(i), (i % 2 == 1) ? 8'h02 : 8'h01, 12'h000,
           i % 2 == 0, 20'h00600 + 20'(i), "R9");
    for (int k = 0; k < 4; k++) fill(20'h00400 + 20'(k), 20'h00700 + 20'(k), 8'h03);
    for (int i = 0; i < 8; i += 2)
      look(20'h00300 + 20'(i), 8'h01, 12'h000, 1'b1, 20'h00600 + 20'(i), "R5");
    for (int k = 0; k < 4; k++)
      look(20'h00400 + 20'(k), 8'h03, 12'h000, 1'b1, 20'h00700 + 20'(k), "R5");
    fill(20'h00500, 20'h00777, 8'h03);
    look(20'h00300, 8'h01, 12'h000, 1'b0, '0, "R6 after holes");
    look(20'h00302, 8'h01, 12'h000, 1'b1, 20'h00602, "R6");
    look(20'h00500, 8'h03, 12'h000, 1'b1, 20'h00777, "R6");
  endtask

  task automatic t_flush_all();
    do_reset();
    fill(20'h00800, 20'h00900, 8'h07);
    @(negedge clk);
    inv_all = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h00801; fill_pfn = 20'h00901; fill_asid = 8'h07;
    @(posedge clk); #1;
    inv_all = 1'b0; fill_en = 1'b0;
    look(20'h00800, 8'h07, 12'h000, 1'b0, '0, "R8");
    look(20'h00801, 8'h07, 12'h000, 1'b0, '0, "R8 refill dropped");
  endtask

  task automatic t_flush_asid_fill();
    do_reset();
    fill(20'h00700, 20'h00A00, 8'h05);
    fill(20'h00701, 20'h00A01, 8'h06);
    @(negedge clk);
    inv_asid_en = 1'b1; inv_asid = 8'h05;
    fill_en = 1'b1; fill_vpn = 20'h00702; fill_pfn = 20'h00A02; fill_asid = 8'h05;
    @(posedge clk); #1;
    inv_asid_en = 1'b0; fill_en = 1'b0;
    look(20'h00700, 8'h05, 12'h000, 1'b0, '0, "R9");
    look(20'h00701, 8'h06, 12'h000, 1'b1, 20'h00A01, "R9");
    look(20'h00702, 8'h05, 12'h000, 1'b1, 20'h00A02, "R9 refill kept");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_rotate();
    t_holes();
    t_flush_all();
    t_flush_asid_fill();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end
endmodule